// File: doc/BRIEF.md
# Biphase-Mark Poll Receiver

This block sits behind a line receiver on a polled multidrop serial link. It takes the raw biphase-mark coded line, sampled by the system clock (nominally 4 MHz, so a half bit lasts 8 clocks), and recovers one bit at a time by measuring the spacing between line transitions. Each recovered bit is announced with a one-cycle strobe. A live bit-value output rises at the start of every bit and falls once the bit has run long enough without a mid-bit transition to be a zero.

Recovered bits are assembled into frames. A frame has a start flag, a 5-bit station address, a data-present flag, an optional 8-bit byte and an even parity bit. When a frame with good parity carries this station's address, the block pulses a reply-start strobe. If that frame also carries a byte, it pulses a load strobe and presents the byte. Any malformed spacing, a stalled line inside a frame, or a missing start flag pulses an abort and sends the receiver back to hunting for a frame. The receiver runs only while its enable input is high.

The bit engine is a four-state machine. `ST_IDLE` waits for enable. `ST_HUNT` waits for the first transition of a frame. `ST_BOUND` follows a bit-boundary transition. `ST_MID` follows a mid-bit transition. The transitions are:
- enable-on: IDLE to HUNT.
- frame-begin: an edge in HUNT, to BOUND.
- half-seen: a half-spaced edge in BOUND, to MID.
- zero-done: a full-spaced edge in BOUND, to BOUND, or to HUNT on the last bit.
- one-done: a half-spaced edge in MID, to BOUND, or to HUNT on the last bit.
- abort: a bad spacing, a stall or a bad start flag, from BOUND or MID to HUNT.
- disable: enable low, from any state to IDLE.

Top module: `biphase_rx`

## Requirements
- R1: After reset `bit_clk`, `abort`, `tx_start` and `rx_load` are 0, `rx_byte` is 0 and `bit_value` is 1.
- R2: Every bit of a frame gives exactly one `bit_clk` pulse. Edge spacings of 6 to 10 clocks are half bits and 14 to 18 clocks are full bits. A one is two half spacings and a zero is one full spacing.
- R3: `bit_value` is 1 from the start of each bit. It drops to 0 once 11 clocks pass with no transition, and during a `bit_clk` pulse it equals the received bit.
- R4: An edge spacing outside both windows pulses `abort` and returns the receiver to HUNT, from where the next well-formed frame is received normally.
- R5: Inside a frame, a spacing above 18 clocks with no edge pulses `abort`. In MID this happens after 10 clocks.
- R6: The first bit of a frame must be 1 (the start flag). A 0 there pulses `abort` and gives no `bit_clk`.
- R7: Bits are sent in this order: start flag, address MSB first, data-present flag, byte MSB first (only when the flag is 1), parity. Parity makes the count of ones over address, flag, byte and parity even. A frame with good parity and address equal to `own_addr` gives one `tx_start` pulse. With the flag 0 it gives no `rx_load`.
- R8: When such a frame has its flag at 1, `rx_load` pulses together with `tx_start`, and `rx_byte` shows the byte from then on. `rx_byte` changes only with `rx_load`.
- R9: A frame for another address gives neither `tx_start` nor `rx_load`.
- R10: A frame with a parity mismatch gives neither `tx_start` nor `rx_load`, and no `abort`.
- R11: While `enable` is 0 the line is ignored: no `bit_clk`, `abort`, `tx_start` or `rx_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Communication enable; reception runs only while 1 |
| own_addr | input | 5 | Address this station answers |
| line_in | input | 1 | Biphase-mark coded line, asynchronous. It must be 0 during reset. |
| bit_clk | output | 1 | One-cycle strobe per correctly received bit |
| bit_value | output | 1 | Live value of the current bit |
| abort | output | 1 | One-cycle strobe on a coding error |
| tx_start | output | 1 | One-cycle strobe: a valid poll for this station arrived |
| rx_load | output | 1 | One-cycle strobe: the poll carried a byte |
| rx_byte | output | 8 | Last byte delivered with `rx_load` |

## Verification
Nominal frames, with and without a byte, check that decoding and field assembly work. Frames built only from the window limits (6/14 and 10/18) show that the tolerance edges are accepted rather than aborted. Single spacings of 5, 11, 12 and 19 clocks, a stalled frame, and a frame whose start flag is 0 separate the three abort causes from one another and from clean recovery afterwards. Randomly jittered frames with random addresses, flags, bytes and corrupted parity test the address match against the parity check. A probe inside a zero bit watches the live bit value rise and then fall.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HUNT  = 2'd1,
        ST_BOUND = 2'd2,
        ST_MID   = 2'd3
    } rx_state_t;
endpackage

// File: rtl/bmr_edge_sync.sv
module bmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic edge_o
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], line_in};
    end

    assign edge_o = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/bmr_interval.sv
module bmr_interval #(
    parameter int HALF = 8,
    parameter int TOL  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic is_half,
    output logic is_full,
    output logic beyond_half,
    output logic overdue
);
    localparam int CW = $clog2(2 * HALF + TOL + 2);
    localparam logic [CW-1:0] HALF_LO = CW'(HALF - TOL);
    localparam logic [CW-1:0] HALF_HI = CW'(HALF + TOL);
    localparam logic [CW-1:0] FULL_LO = CW'(2 * HALF - TOL);
    localparam logic [CW-1:0] FULL_HI = CW'(2 * HALF + TOL);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (restart)    cnt <= CW'(1);
        else if (~&cnt)      cnt <= cnt + 1'b1;
    end

    assign is_half     = (cnt >= HALF_LO) && (cnt <= HALF_HI);
    assign is_full     = (cnt >= FULL_LO) && (cnt <= FULL_HI);
    assign beyond_half = cnt > HALF_HI;
    assign overdue     = cnt > FULL_HI;
endmodule

// File: rtl/bmr_frame.sv
module bmr_frame #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              at_start,
    output logic              at_last,
    output logic              tx_start,
    output logic              rx_load,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int NBITS = ADDR_W + DATA_W + 3;
    localparam int IW    = $clog2(NBITS + 1);
    localparam logic [IW-1:0] P_FLAG  = IW'(ADDR_W + 1);
    localparam logic [IW-1:0] P_PAR_S = IW'(ADDR_W + 2);
    localparam logic [IW-1:0] P_PAR_L = IW'(ADDR_W + DATA_W + 2);

    logic [IW-1:0]     idx;
    logic              flag_q, par_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              in_addr, in_data, accept;

    assign at_start = idx == '0;
    assign at_last  = idx == (flag_q ? P_PAR_L : P_PAR_S);
    assign in_addr  = (idx != '0) && (idx < P_FLAG);
    assign in_data  = flag_q && (idx >= P_PAR_S) && (idx < P_PAR_L);
    assign accept   = !(par_q ^ bit_val) && (addr_q == own_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0; flag_q <= 1'b0; par_q <= 1'b0;
            addr_q <= '0; data_q <= '0;
            tx_start <= 1'b0; rx_load <= 1'b0; rx_byte <= '0;
        end else begin
            tx_start <= 1'b0;
            rx_load  <= 1'b0;
            if (clear) begin
                idx <= '0; flag_q <= 1'b0; par_q <= 1'b0;
            end else if (bit_stb) begin
                if (at_last) begin
                    idx <= '0; flag_q <= 1'b0; par_q <= 1'b0;
                    if (accept) begin
                        tx_start <= 1'b1;
                        if (flag_q) begin
                            rx_load <= 1'b1;
                            rx_byte <= data_q;
                        end
                    end
                end else begin
                    idx <= idx + 1'b1;
                    if (!at_start)     par_q  <= par_q ^ bit_val;
                    if (in_addr)       addr_q <= {addr_q[ADDR_W-2:0], bit_val};
                    if (idx == P_FLAG) flag_q <= bit_val;
                    if (in_data)       data_q <= {data_q[DATA_W-2:0], bit_val};
                end
            end
        end
    end

    assert_load_implies_reply_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |-> tx_start);
    assert_byte_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_load |-> $stable(rx_byte));
    assert_reply_follows_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(bit_stb));
endmodule

// File: rtl/biphase_rx.sv
module biphase_rx
    import bmr_pkg::*;
#(
    parameter int HALF_CLKS = 8,
    parameter int TOL       = 2,
    parameter int SYNC      = 2,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              line_in,
    output logic              bit_clk,
    output logic              bit_value,
    output logic              abort,
    output logic              tx_start,
    output logic              rx_load,
    output logic [DATA_W-1:0] rx_byte
);
    rx_state_t state, nxt;
    logic edge_w, is_half, is_full, beyond_half, overdue;
    logic at_start, at_last;
    logic bit_done, err, good_bit, bad_flag, bit_q;

    bmr_edge_sync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .edge_o(edge_w));

    bmr_interval #(.HALF(HALF_CLKS), .TOL(TOL)) u_gap (
        .clk(clk), .rst_n(rst_n), .restart(edge_w),
        .is_half(is_half), .is_full(is_full),
        .beyond_half(beyond_half), .overdue(overdue));

    always_comb begin
        nxt      = state;
        bit_done = 1'b0;
        err      = 1'b0;
        unique case (state)
            ST_IDLE:  if (enable) nxt = ST_HUNT;
            ST_HUNT:  if (edge_w) nxt = ST_BOUND;
            ST_BOUND: begin
                if (edge_w) begin
                    if (is_half)      nxt = ST_MID;
                    else if (is_full) bit_done = 1'b1;
                    else              err = 1'b1;
                end else if (overdue) err = 1'b1;
            end
            ST_MID: begin
                if (edge_w) begin
                    if (is_half) bit_done = 1'b1;
                    else         err = 1'b1;
                end else if (beyond_half) err = 1'b1;
            end
        endcase
        bad_flag = bit_done && at_start && !bit_q;
        good_bit = bit_done && !bad_flag;
        if (good_bit) nxt = at_last ? ST_HUNT : ST_BOUND;
        if (bad_flag) err = 1'b1;
        if (err)      nxt = ST_HUNT;
        if (!enable) begin
            nxt      = ST_IDLE;
            good_bit = 1'b0;
            err      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bit_q <= 1'b1;
        else if (edge_w && enable && (state == ST_HUNT || good_bit))
            bit_q <= 1'b1;
        else if (state == ST_BOUND && beyond_half)
            bit_q <= 1'b0;
    end

    assign bit_clk   = good_bit;
    assign bit_value = bit_q;
    assign abort     = err;

    bmr_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .clear(state == ST_IDLE || state == ST_HUNT || err),
        .bit_stb(good_bit), .bit_val(bit_q), .own_addr(own_addr),
        .at_start(at_start), .at_last(at_last),
        .tx_start(tx_start), .rx_load(rx_load), .rx_byte(rx_byte));

    assert_abort_rehunts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == ST_HUNT || state == ST_IDLE));
    assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !bit_clk);
    assert_bit_ends_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_clk && state == ST_MID) |-> bit_value);
    assert_no_bit_and_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_clk && abort));
endmodule

// File: tb/test_biphase_rx.sv
module test_biphase_rx;
    localparam logic [4:0] OWN = 5'h0B;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b1, line_in = 1'b0;
    logic bit_clk, bit_value, abort, tx_start, rx_load;
    logic [7:0] rx_byte;

    int total = 0, fails = 0, nbits = 0, naborts = 0, ntx = 0, nrx = 0;
    logic [31:0] seq = '0;
    logic [7:0] got_byte = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    biphase_rx i_biphase_rx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .own_addr(OWN),
        .line_in(line_in), .bit_clk(bit_clk), .bit_value(bit_value),
        .abort(abort), .tx_start(tx_start), .rx_load(rx_load), .rx_byte(rx_byte));

    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_clk) begin nbits++; seq = {seq[30:0], bit_value}; end
            if (abort)    naborts++;
            if (tx_start) ntx++;
            if (rx_load)  begin nrx++; got_byte = rx_byte; end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic tog();
        line_in = ~line_in;
    endtask

    task automatic send_bit(input logic v, input int h1, input int h2);
        tog();
        if (v) begin wclk(h1); tog(); wclk(h2); end
        else   wclk(h1 + h2);
    endtask

    task automatic clear_mon();
        nbits = 0; naborts = 0; ntx = 0; nrx = 0; seq = '0;
    endtask

    function automatic logic [31:0] build(input logic [4:0] a, input logic dp,
                                          input logic [7:0] d, input logic flip);
        logic p;
        p = (^a) ^ dp ^ (dp ? ^d : 1'b0) ^ flip;
        if (dp) return {16'h0, 1'b1, a, 1'b1, d, p};
        return {24'h0, 1'b1, a, 1'b0, p};
    endfunction

    // mode 0 nominal, 1 random jitter, 2 low window limits, 3 high window limits
    task automatic send_frame(input logic [4:0] a, input logic dp, input logic [7:0] d,
                              input logic flip, input int mode, input int probe);
        logic [31:0] fv;
        int len, h1, h2;
        fv  = build(a, dp, d, flip);
        len = dp ? 16 : 8;
        for (int i = len - 1; i >= 0; i--) begin
            case (mode)
                1:       begin h1 = $urandom_range(7, 9); h2 = $urandom_range(7, 9); end
                2:       begin h1 = 6;  h2 = fv[i] ? 6 : 8; end
                3:       begin h1 = 10; h2 = 8 + (fv[i] ? 2 : 0); end
                default: begin h1 = 8;  h2 = 8; end
            endcase
            if (i == len - 1 - probe && !fv[i]) begin
                tog();
                wclk(4);
                chk("R3 value high early in zero bit", int'(bit_value), 1);
                wclk(10);
                chk("R3 value low late in zero bit", int'(bit_value), 0);
                wclk(2);
            end else begin
                send_bit(fv[i], h1, h2);
            end
        end
        tog();
        wclk(40);
    endtask

    task automatic run_frame(input string req, input logic [4:0] a, input logic dp,
                             input logic [7:0] d, input logic flip, input int mode,
                             input int probe);
        logic [31:0] fv, mask;
        int len, etx;
        clear_mon();
        send_frame(a, dp, d, flip, mode, probe);
        fv   = build(a, dp, d, flip);
        len  = dp ? 16 : 8;
        mask = (32'h1 << len) - 1;
        etx  = (a == OWN && !flip) ? 1 : 0;
        chk({req, " R2 bit count"}, nbits, len);
        chk({req, " R3 bit values"}, int'(seq & mask), int'(fv));
        chk({req, " R7 tx_start"}, ntx, etx);
        chk({req, " R8 rx_load"}, nrx, (etx == 1 && dp) ? 1 : 0);
        if (etx == 1 && dp) chk({req, " R8 rx_byte"}, int'(got_byte), int'(d));
        chk({req, " R10 no abort"}, naborts, 0);
    endtask

    task automatic bad_gap(input string req, input int n);
        clear_mon();
        tog(); wclk(n); tog(); wclk(40);
        chk({req, " abort seen"}, int'(naborts > 0), 1);
        chk({req, " no bit"}, nbits, 0);
        chk({req, " no reply"}, ntx, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        #1;
        wclk(5);
        chk("R1 bit_clk", int'(bit_clk), 0);
        chk("R1 abort", int'(abort), 0);
        chk("R1 tx_start", int'(tx_start), 0);
        chk("R1 rx_load", int'(rx_load), 0);
        chk("R1 rx_byte", int'(rx_byte), 0);
        chk("R1 bit_value", int'(bit_value), 1);
        rst_n = 1'b1;
        wclk(10);

        run_frame("R7 own poll", OWN, 1'b0, 8'h00, 1'b0, 0, 1);
        run_frame("R8 own poll byte", OWN, 1'b1, 8'hA5, 1'b0, 0, -1);
        run_frame("R9 other addr", 5'h14, 1'b1, 8'h3C, 1'b0, 0, -1);
        run_frame("R10 bad parity", OWN, 1'b1, 8'h5A, 1'b1, 0, -1);
        run_frame("R2 low limits", OWN, 1'b1, 8'h96, 1'b0, 2, -1);
        run_frame("R2 high limits", OWN, 1'b1, 8'h69, 1'b0, 3, -1);

        bad_gap("R4 gap 5", 5);
        bad_gap("R4 gap 11", 11);
        bad_gap("R4 gap 12", 12);
        bad_gap("R5 gap 19", 19);
        run_frame("R4 recovery", OWN, 1'b1, 8'hC3, 1'b0, 0, -1);

        clear_mon();
        send_bit(1'b0, 8, 8); tog(); wclk(40);
        chk("R6 bad flag abort", int'(naborts > 0), 1);
        chk("R6 bad flag no bit", nbits, 0);

        clear_mon();
        send_bit(1'b1, 8, 8); send_bit(1'b1, 8, 8); send_bit(1'b0, 8, 8);
        wclk(40);
        chk("R5 stall abort", naborts, 1);
        chk("R5 stall bits", nbits, 2);
        chk("R5 stall reply", ntx, 0);

        enable = 1'b0;
        wclk(3);
        clear_mon();
        send_frame(OWN, 1'b1, 8'h11, 1'b0, 0, -1);
        chk("R11 disabled bits", nbits, 0);
        chk("R11 disabled reply", ntx + nrx + naborts, 0);
        chk("R11 byte kept", int'(rx_byte), 8'hC3);
        enable = 1'b1;
        wclk(5);
        run_frame("R11 reenabled", OWN, 1'b0, 8'h00, 1'b0, 0, -1);

        for (int k = 0; k < 30; k++) begin
            logic [4:0] a;
            logic [7:0] d;
            a = ($urandom_range(0, 1) == 1) ? OWN : 5'($urandom);
            d = 8'($urandom);
            run_frame("R9 random", a, 1'($urandom), d,
                      $urandom_range(0, 4) == 0, 1, -1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
            $finish;
        end
    end
endmodule